// File: doc/BRIEF.md
# SD Card Single-Block Data Phase Engine

This block carries out the data phase of one SD card block transfer over SPI, once the controller above it has issued the read or write command and seen it accepted. It drives the card through a byte-wide SPI master port: each byte is one request/acknowledge exchange, in which one byte goes out and one comes back. The block also owns the card's chip select.

On a read, the engine clocks out fill bytes until the card returns the start token. It then captures the payload bytes and hands them to the local side in order, one valid strobe per byte. It reads the two CRC bytes that follow and drops them.

On a write, the engine sends the start token and then pulls the payload from the local side one byte at a time. It sends two fill bytes where the CRC would go, then fetches and classifies the card's data response token. If the card accepts the block, the engine waits while the card signals busy.

Each transfer ends the same way: chip select goes high, one trailing fill byte is clocked, and the engine gives a one-cycle done pulse with a result code. The payload length is given at start time, so the same path serves short register blocks (16 bytes) and full 512-byte sectors. The wait for the start token and the busy wait each have their own retry limit, so a card that never answers still lets the transfer end.

Top module: `sdblk_xfer_engine`

## Requirements
- R1: During and after reset, `cs_n_o` is high and `spi_req_o`, `busy_o`, `done_o`, `rd_valid_o` and `wr_take_o` are low.
- R2: A read (`dir_wr_i`=0) sends 0xFF with `cs_n_o` low until a received byte equals 0xFE. Each of the next `len_i` received bytes appears on `rd_data_o`, in order, with `rd_valid_o` high for one cycle; this happens in the cycle after that byte's `spi_ack_i`. A 0xFE byte inside the payload is treated as data.
- R3: After a read payload, two more 0xFF bytes are clocked with `cs_n_o` low and are not output. Then one 0xFF byte is clocked with `cs_n_o` high, and `result_o` reports 0 (success).
- R4: If `HUNT_LIMIT` received bytes all differ from 0xFE, the engine clocks one 0xFF byte with `cs_n_o` high and reports `result_o`=1. A 0xFE arriving on exactly the `HUNT_LIMIT`-th byte still starts the payload.
- R5: A write (`dir_wr_i`=1) sends 0xFE, then `len_i` bytes taken from `wr_data_i`, then 0xFF twice, then one more 0xFF that fetches the response token, all with `cs_n_o` low. Each payload byte is consumed by a one-cycle `wr_take_o` pulse in the cycle of its `spi_ack_i`.
- R6: A response token whose low five bits differ from 5'b00101 is a rejection. The engine clocks one 0xFF byte with `cs_n_o` high and reports `result_o`=2. In every write, `resp_code_o` holds bits [3:1] of the token (3'b101 for a CRC error, 3'b110 for a write error).
- R7: After an accepted token, 0xFF is clocked with `cs_n_o` low for as long as the card returns 0x00. At the first nonzero byte, one 0xFF byte is clocked with `cs_n_o` high and `result_o` reports 0.
- R8: If `BUSY_LIMIT` consecutive 0x00 bytes arrive in the busy wait, the engine clocks one 0xFF byte with `cs_n_o` high and reports `result_o`=3.
- R9: The payload length is sampled from `len_i` at start. A length of zero skips the payload: on a read the start token is followed directly by the two CRC bytes, and on a write likewise.
- R10: `start_i` has no effect while `busy_o` is high. The byte stream and the result of the running transfer are unchanged.
- R11: `busy_o` rises in the cycle after an accepted `start_i`. `done_o` is a one-cycle pulse with `busy_o` low, and `result_o` and `resp_code_o` are valid with it.
- R12: Once raised, `spi_req_o` stays high with `spi_tx_o` stable until `spi_ack_i` completes the byte. `cs_n_o` is low only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a data phase (sampled when idle) |
| dir_wr_i | input | 1 | 1 = write block, 0 = read block |
| len_i | input | LEN_W | Payload length in bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 start-token timeout, 2 token rejected, 3 busy timeout |
| resp_code_o | output | 3 | Status field of the last write response token |
| rd_valid_o | output | 1 | Read payload byte strobe |
| rd_data_o | output | 8 | Read payload byte |
| wr_take_o | output | 1 | Write payload byte consumed |
| wr_data_i | input | 8 | Write payload byte, held until taken |
| spi_req_o | output | 1 | Byte exchange request |
| spi_tx_o | output | 8 | Byte to send |
| spi_ack_i | input | 1 | Byte exchange complete |
| spi_rx_i | input | 8 | Byte received, valid with ack |
| cs_n_o | output | 1 | Card chip select, active low |

## Verification
The embedded assertions check on every cycle that:
- a request holds steady until it is acknowledged;
- chip select never drops outside a transfer;
- done is a single cycle and only follows a start;
- read strobes occur only with chip select low;
- the retry counters never pass their limits.

Only the bench scenarios can show the framing itself: the exact order of token, payload, fill and trailing bytes, and how the response token is classified. The same holds for the boundary cases: a start token on the last allowed try, a release on the last allowed busy byte, zero-length payloads, and a start pulse arriving mid-transfer.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;

    localparam logic [7:0] START_TOKEN = 8'hFE;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [4:0] ACCEPT_PAT  = 5'b00101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HUNT,
        ST_RD_DATA,
        ST_RD_CRC,
        ST_WR_TOK,
        ST_WR_DATA,
        ST_WR_CRC,
        ST_WR_RESP,
        ST_WR_BUSY,
        ST_TAIL
    } xfer_state_e;

    typedef enum logic [1:0] {
        RES_OK           = 2'd0,
        RES_HUNT_TIMEOUT = 2'd1,
        RES_REJECTED     = 2'd2,
        RES_BUSY_TIMEOUT = 2'd3
    } xfer_result_e;

    typedef struct packed {
        logic       is_start;
        logic       is_busy;
        logic       accepted;
        logic [2:0] code;
    } tok_info_t;

    function automatic tok_info_t classify(input logic [7:0] b);
        tok_info_t t;
        t.is_start = (b == START_TOKEN);
        t.is_busy  = (b == 8'h00);
        t.accepted = (b[4:0] == ACCEPT_PAT);
        t.code     = b[3:1];
        return t;
    endfunction

endpackage

// File: rtl/sdblk_countdown.sv
module sdblk_countdown #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign is_zero = (cnt_q == '0);
    assign is_last = (cnt_q == W'(1));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/sdblk_retry.sv
module sdblk_retry #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (step && !expire)
            cnt_q <= cnt_q + CW'(1);
    end

    assign expire = step && (cnt_q == CW'(LIMIT - 1));

    // R4 R8
    retry_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < LIMIT);
endmodule

// File: rtl/sdblk_token_decode.sv
module sdblk_token_decode
    import sdblk_pkg::*;
(
    input  logic [7:0] rx_byte,
    output tok_info_t  info
);
    always_comb info = classify(rx_byte);
endmodule

// File: rtl/sdblk_xfer_engine.sv
module sdblk_xfer_engine
    import sdblk_pkg::*;
#(
    parameter int LEN_W      = 10,
    parameter int HUNT_LIMIT = 5000,
    parameter int BUSY_LIMIT = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dir_wr_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       result_o,
    output logic [2:0]       resp_code_o,
    output logic             rd_valid_o,
    output logic [7:0]       rd_data_o,
    output logic             wr_take_o,
    input  logic [7:0]       wr_data_i,
    output logic             spi_req_o,
    output logic [7:0]       spi_tx_o,
    input  logic             spi_ack_i,
    input  logic [7:0]       spi_rx_i,
    output logic             cs_n_o
);
    xfer_state_e  state_q;
    xfer_result_e result_q;
    logic         crc_second_q;
    logic [2:0]   resp_code_q;
    logic         done_q;
    logic         rd_valid_q;
    logic [7:0]   rd_data_q;

    tok_info_t tok;
    logic      ack;
    logic      launch;
    logic      cnt_dec, cnt_zero, cnt_last;
    logic      hunt_step, hunt_exp;
    logic      bsy_step, bsy_exp;

    assign ack    = spi_req_o && spi_ack_i;
    assign launch = (state_q == ST_IDLE) && start_i;

    sdblk_token_decode u_tok (
        .rx_byte (spi_rx_i),
        .info    (tok)
    );

    assign cnt_dec = ack && (state_q == ST_RD_DATA || state_q == ST_WR_DATA);

    sdblk_countdown #(.W(LEN_W)) u_len (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (len_i),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero),
        .is_last  (cnt_last)
    );

    assign hunt_step = ack && (state_q == ST_HUNT) && !tok.is_start;
    assign bsy_step  = ack && (state_q == ST_WR_BUSY) && tok.is_busy;

    sdblk_retry #(.LIMIT(HUNT_LIMIT)) u_hunt_retry (
        .clk    (clk),
        .rst    (rst),
        .clr    (launch),
        .step   (hunt_step),
        .expire (hunt_exp)
    );

    sdblk_retry #(.LIMIT(BUSY_LIMIT)) u_busy_retry (
        .clk    (clk),
        .rst    (rst),
        .clr    (launch),
        .step   (bsy_step),
        .expire (bsy_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            result_q     <= RES_OK;
            crc_second_q <= 1'b0;
            resp_code_q  <= '0;
            done_q       <= 1'b0;
            rd_valid_q   <= 1'b0;
            rd_data_q    <= '0;
        end else begin
            done_q     <= 1'b0;
            rd_valid_q <= ack && (state_q == ST_RD_DATA);
            if (ack && state_q == ST_RD_DATA)
                rd_data_q <= spi_rx_i;

            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        result_q     <= RES_OK;
                        resp_code_q  <= '0;
                        crc_second_q <= 1'b0;
                        state_q      <= dir_wr_i ? ST_WR_TOK : ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (ack) begin
                        if (tok.is_start)
                            state_q <= cnt_zero ? ST_RD_CRC : ST_RD_DATA;
                        else if (hunt_exp) begin
                            result_q <= RES_HUNT_TIMEOUT;
                            state_q  <= ST_TAIL;
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (ack && cnt_last)
                        state_q <= ST_RD_CRC;
                end
                ST_RD_CRC: begin
                    if (ack) begin
                        crc_second_q <= 1'b1;
                        if (crc_second_q) begin
                            result_q <= RES_OK;
                            state_q  <= ST_TAIL;
                        end
                    end
                end
                ST_WR_TOK: begin
                    if (ack)
                        state_q <= cnt_zero ? ST_WR_CRC : ST_WR_DATA;
                end
                ST_WR_DATA: begin
                    if (ack && cnt_last)
                        state_q <= ST_WR_CRC;
                end
                ST_WR_CRC: begin
                    if (ack) begin
                        crc_second_q <= 1'b1;
                        if (crc_second_q)
                            state_q <= ST_WR_RESP;
                    end
                end
                ST_WR_RESP: begin
                    if (ack) begin
                        resp_code_q <= tok.code;
                        if (tok.accepted)
                            state_q <= ST_WR_BUSY;
                        else begin
                            result_q <= RES_REJECTED;
                            state_q  <= ST_TAIL;
                        end
                    end
                end
                ST_WR_BUSY: begin
                    if (ack) begin
                        if (!tok.is_busy) begin
                            result_q <= RES_OK;
                            state_q  <= ST_TAIL;
                        end else if (bsy_exp) begin
                            result_q <= RES_BUSY_TIMEOUT;
                            state_q  <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (ack) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            ST_WR_TOK:  spi_tx_o = START_TOKEN;
            ST_WR_DATA: spi_tx_o = wr_data_i;
            default:    spi_tx_o = FILL_BYTE;
        endcase
    end

    assign spi_req_o   = (state_q != ST_IDLE);
    assign cs_n_o      = (state_q == ST_IDLE) || (state_q == ST_TAIL);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign result_o    = result_q;
    assign resp_code_o = resp_code_q;
    assign rd_valid_o  = rd_valid_q;
    assign rd_data_o   = rd_data_q;
    assign wr_take_o   = ack && (state_q == ST_WR_DATA);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o)));

    // R12
    cs_inside_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o ##1 !done_o));

    // R10
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R2
    rd_strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> !cs_n_o);
endmodule

// File: tb/sdblk_xfer_engine_tb_top.sv
module sdblk_xfer_engine_tb_top;
    localparam int LEN_W = 10;
    localparam int HL    = 8;
    localparam int BL    = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             dir_wr_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic             busy_o, done_o, rd_valid_o, wr_take_o, spi_req_o, cs_n_o;
    logic [1:0]       result_o;
    logic [2:0]       resp_code_o;
    logic [7:0]       rd_data_o, spi_tx_o, wr_data_i;
    logic             spi_ack_i = 1'b0;
    logic [7:0]       spi_rx_i = 8'hFF;

    int checks = 0;
    int errors = 0;

    logic [8:0] exp_tx[$];
    logic [7:0] card_rx[$];
    logic [7:0] exp_rd[$];
    string      cur_req = "R1";

    logic [7:0] wpat [0:511];
    int         wr_idx = 0;

    always #5 clk = ~clk;

    sdblk_xfer_engine #(.LEN_W(LEN_W), .HUNT_LIMIT(HL), .BUSY_LIMIT(BL)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_wr_i(dir_wr_i), .len_i(len_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .resp_code_o(resp_code_o),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .wr_take_o(wr_take_o),
        .wr_data_i(wr_data_i), .spi_req_o(spi_req_o), .spi_tx_o(spi_tx_o),
        .spi_ack_i(spi_ack_i), .spi_rx_i(spi_rx_i), .cs_n_o(cs_n_o)
    );

    assign wr_data_i = wpat[wr_idx % 512];

    always @(posedge clk) if (wr_take_o) wr_idx <= wr_idx + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // card model and transmit-side monitor
    initial begin
        forever begin
            @(negedge clk);
            spi_ack_i = 1'b0;
            if (spi_req_o) begin
                @(negedge clk);
                if (exp_tx.size() == 0)
                    chk(1'b0, {cur_req, " unexpected byte"}, {cs_n_o, spi_tx_o}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_tx.pop_front();
                    chk({cs_n_o, spi_tx_o} == e, {cur_req, " tx byte/cs"}, {cs_n_o, spi_tx_o}, e);
                end
                spi_rx_i  = (card_rx.size() != 0) ? card_rx.pop_front() : 8'hFF;
                spi_ack_i = 1'b1;
            end
        end
    end

    // read-side monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid_o) begin
                if (exp_rd.size() == 0)
                    chk(1'b0, {cur_req, " unexpected read strobe"}, rd_data_o, 0);
                else begin
                    logic [7:0] d;
                    d = exp_rd.pop_front();
                    chk(rd_data_o == d, {cur_req, " read byte"}, rd_data_o, d);
                end
            end
        end
    end

    task automatic ex(input logic cs, input logic [7:0] b);
        exp_tx.push_back({cs, b});
    endtask

    task automatic run(input logic wr, input int len, input int eres, input int ecode,
                       input bit inject);
        bit got;
        @(negedge clk);
        start_i  = 1'b1;
        dir_wr_i = wr;
        len_i    = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
        // R11
        chk(busy_o == 1'b1, {cur_req, " R11 busy after start"}, busy_o, 1);
        if (inject) begin
            repeat (15) @(negedge clk);
            // R10: a new start mid-transfer with other settings
            start_i  = 1'b1;
            dir_wr_i = ~wr;
            len_i    = LEN_W'(3);
            @(negedge clk);
            start_i = 1'b0;
        end
        got = 1'b0;
        for (int i = 0; i < 20000 && !got; i++) begin
            if (done_o) got = 1'b1;
            else @(negedge clk);
        end
        chk(got, {cur_req, " R11 done seen"}, got, 1);
        chk(busy_o == 1'b0, {cur_req, " R11 idle at done"}, busy_o, 0);
        chk(result_o == 2'(eres), {cur_req, " result"}, result_o, eres);
        chk(resp_code_o == 3'(ecode), {cur_req, " resp code"}, resp_code_o, ecode);
        @(negedge clk);
        chk(done_o == 1'b0, {cur_req, " R11 done one cycle"}, done_o, 0);
        repeat (6) @(negedge clk);
        chk(spi_req_o == 1'b0 && cs_n_o == 1'b1, {cur_req, " quiet after done"},
            {spi_req_o, cs_n_o}, 1);
        chk(exp_tx.size() == 0, {cur_req, " all tx bytes seen"}, exp_tx.size(), 0);
        chk(exp_rd.size() == 0, {cur_req, " all read bytes seen"}, exp_rd.size(), 0);
        chk(card_rx.size() == 0, {cur_req, " card script used"}, card_rx.size(), 0);
        exp_tx.delete(); exp_rd.delete(); card_rx.delete();
    endtask

    task automatic read_case(input int len, input int pre_ff, input int seed, input bit inject);
        for (int i = 0; i < pre_ff; i++) begin card_rx.push_back(8'hFF); ex(1'b0, 8'hFF); end
        card_rx.push_back(8'hFE); ex(1'b0, 8'hFF);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = 8'((i * 37 + seed) & 255);
            if (i == 1) d = 8'hFE;
            card_rx.push_back(d); ex(1'b0, 8'hFF); exp_rd.push_back(d);
        end
        card_rx.push_back(8'h12); ex(1'b0, 8'hFF);
        card_rx.push_back(8'h34); ex(1'b0, 8'hFF);
        card_rx.push_back(8'hFF); ex(1'b1, 8'hFF);
        run(1'b0, len, 0, 0, inject);
    endtask

    task automatic write_case(input int len, input logic [7:0] tok, input int nbusy,
                              input bit inject);
        int base, eres;
        base = wr_idx;
        ex(1'b0, 8'hFE); card_rx.push_back(8'hFF);
        for (int i = 0; i < len; i++) begin
            ex(1'b0, wpat[(base + i) % 512]); card_rx.push_back(8'hFF);
        end
        ex(1'b0, 8'hFF); card_rx.push_back(8'hFF);
        ex(1'b0, 8'hFF); card_rx.push_back(8'hFF);
        ex(1'b0, 8'hFF); card_rx.push_back(tok);
        if (tok[4:0] != 5'b00101) eres = 2;
        else begin
            int nz;
            nz = (nbusy < BL) ? nbusy : BL;
            for (int k = 0; k < nz; k++) begin ex(1'b0, 8'hFF); card_rx.push_back(8'h00); end
            if (nbusy < BL) begin ex(1'b0, 8'hFF); card_rx.push_back(8'h3C); eres = 0; end
            else eres = 3;
        end
        ex(1'b1, 8'hFF); card_rx.push_back(8'hFF);
        run(1'b1, len, eres, int'(tok[3:1]), inject);
        chk(wr_idx - base == len, {cur_req, " R5 bytes taken"}, wr_idx - base, len);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) wpat[i] = 8'((i * 29 + 11) & 255);
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(cs_n_o == 1'b1, "R1 cs_n in reset", cs_n_o, 1);
        chk({spi_req_o, busy_o, done_o, rd_valid_o, wr_take_o} == 5'b0, "R1 outputs in reset",
            {spi_req_o, busy_o, done_o, rd_valid_o, wr_take_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs_n_o == 1'b1 && spi_req_o == 1'b0, "R1 idle after reset", {cs_n_o, spi_req_o}, 2);

        cur_req = "R2 R3 read16";      read_case(16, 3, 5, 1'b0);
        cur_req = "R2 R3 read512";     read_case(512, 0, 9, 1'b0);
        cur_req = "R4 hunt boundary";  read_case(4, HL - 1, 2, 1'b0);
        cur_req = "R9 read len0";      read_case(0, 1, 0, 1'b0);

        cur_req = "R4 hunt timeout";
        for (int i = 0; i < HL; i++) ex(1'b0, 8'hFF);
        ex(1'b1, 8'hFF);
        run(1'b0, 16, 1, 0, 1'b0);

        cur_req = "R5 R7 write16";       write_case(16, 8'hE5, 3, 1'b0);
        cur_req = "R5 R7 write512";      write_case(512, 8'h05, 0, 1'b0);
        cur_req = "R6 reject crc";       write_case(8, 8'h0B, 0, 1'b0);
        cur_req = "R6 reject write";     write_case(8, 8'h0D, 0, 1'b0);
        cur_req = "R8 busy timeout";     write_case(4, 8'h05, BL, 1'b0);
        cur_req = "R8 busy boundary";    write_case(4, 8'h05, BL - 1, 1'b0);
        cur_req = "R9 write len0";       write_case(0, 8'h05, 1, 1'b0);
        cur_req = "R10 start ignored w"; write_case(16, 8'h05, 2, 1'b1);
        cur_req = "R10 start ignored r"; read_case(16, 2, 7, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog %s: actual hung expected done", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule